// File: doc/BRIEF.md
# Host Mailbox Status Synchronizer

This block sits between a processor core and an external host and lets them pass data words to each other through a set of mailboxes. There are `N_BOX` inbound mailboxes, which the host fills and the core drains, and `N_BOX` outbound mailboxes, which the core fills and the host drains. Each mailbox has one flag bit. The flag bit is set while the mailbox holds a word that the other side has not yet read. All flags live in the core clock domain. The host reaches the mailboxes and two status words through a strobe-driven bus. That bus has no relation to the core clock.

Each host strobe passes through a two-flop synchronizer. The synchronized level is then edge-detected, so that the start and the end of every host access land on known core cycles. Each side reads status from its own view register. A view register copies the live flags one cycle late. It holds its value for as long as a read by its owner is in progress. A flag change that arrives during a read reaches the view once the read has ended.

On the core side the mailboxes are two valid/ready ports. The inbound port offers the word of the selected mailbox, and `core_in_valid` reports that mailbox's flag. A cycle with valid and ready both high is a transfer, and the transfer clears the flag. The outbound port shows back-pressure through `core_out_ready`, which is low while the selected mailbox still holds a word the host has not read. The core must hold its word until a cycle with ready high. No write is taken while ready is low.

Top module: `hmbox_sync`

## Requirements
- R1: A synchronous active-high reset clears every flag, every mailbox register and both status views. After reset both status words read 0, `core_in_valid` is 0 and `core_out_ready` is 1.
- R2: A host write to address i (i < N_BOX) stores `host_wdata` in inbound mailbox i and sets inbound flag i. After that the core sees `core_in_valid`=1 and the stored word when `core_in_sel`=i.
- R3: A core-side transfer (`core_in_valid` and `core_in_ready` high in the same cycle) clears the inbound flag of the selected mailbox. If a host write commits to the same mailbox in that same cycle, the set wins.
- R4: `core_out_ready` is the inverse of the outbound flag of the selected mailbox. An accepted core write stores the word and sets that flag. While the flag is set, no write is taken and the stored word is unchanged.
- R5: A host read of address N_BOX+i returns outbound mailbox i. Outbound flag i clears once the synchronized read strobe has fallen.
- R6: Host address 2*N_BOX returns the inbound flags and address 2*N_BOX+1 returns the outbound flags, with bit i for mailbox i and all higher bits 0. The core reads the same words on `core_h2c_status` and `core_c2h_status`.
- R7: The host status view does not change while either synchronized host strobe is high. Flag changes made during that window appear after it.
- R8: The core status view does not change while `core_stat_rd` is high. Flag changes made during that window appear after it is released.
- R9: While its view is not held, each status view equals the live flags of the previous core cycle, so a flag change reaches a status output exactly one cycle after the change.
- R10: A host write's flag is set on the third core clock edge after the raw write strobe falls, and not on an earlier edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Host read strobe, asynchronous, active high |
| host_wr | input | 1 | Host write strobe, asynchronous, active high |
| host_addr | input | AW | Host address; held stable for the whole access |
| host_wdata | input | DW | Host write data; held stable while the write strobe is high |
| host_rdata | output | DW | Host read data for the addressed mailbox or status word |
| core_in_sel | input | SW | Inbound mailbox selected on the core side |
| core_in_valid | output | 1 | Selected inbound mailbox holds unread data |
| core_in_data | output | DW | Word held in the selected inbound mailbox |
| core_in_ready | input | 1 | Core takes the offered word |
| core_out_sel | input | SW | Outbound mailbox selected on the core side |
| core_out_valid | input | 1 | Core offers a word for the selected outbound mailbox |
| core_out_data | input | DW | Word offered by the core |
| core_out_ready | output | 1 | Selected outbound mailbox is free |
| core_stat_rd | input | 1 | Core status read in progress; holds the core view |
| core_h2c_status | output | DW | Core view of the inbound flags |
| core_c2h_status | output | DW | Core view of the outbound flags |

## Verification
The hardest case to reach from the ports is a flag change that lands inside a host status read. The read strobe is asynchronous, and the view is held only once the synchronizer has passed the strobe through. To reach this case, the bench raises the read strobe at a random offset within the clock period and holds it for several cycles. While the strobe is still high, it performs a core-side transfer that clears a flag. It then checks that the value on `host_rdata` at the end of the read is the value from before the transfer, and that a later read shows the cleared flag. The core view is tested the same way: a host write is made while `core_stat_rd` is held.

// File: rtl/hmbox_pkg.sv
package hmbox_pkg;

  // host address map: inbound boxes, outbound boxes, then two status words
  function automatic int hmbox_addr_bits(input int n_box);
    return $clog2(2 * n_box + 2);
  endfunction

  function automatic int hmbox_sel_bits(input int n_box);
    return (n_box > 1) ? $clog2(n_box) : 1;
  endfunction

endpackage

// File: rtl/hmbox_strobe_sync.sv
module hmbox_strobe_sync (
  input  logic clk,
  input  logic rst,
  input  logic strobe_async,
  output logic level,
  output logic rise,
  output logic fall
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= strobe_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level = sync_q;
  assign rise  = sync_q & ~prev_q;
  assign fall  = ~sync_q & prev_q;
endmodule

// File: rtl/hmbox_flag_bank.sv
module hmbox_flag_bank #(
  parameter int N_BOX = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_BOX-1:0] set_vec,
  input  logic [N_BOX-1:0] clr_vec,
  output logic [N_BOX-1:0] flags
);
  for (genvar i = 0; i < N_BOX; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)             flags[i] <= 1'b0;
      else if (set_vec[i]) flags[i] <= 1'b1;
      else if (clr_vec[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/hmbox_stat_view.sv
module hmbox_stat_view #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] live,
  output logic [W-1:0] view
);
  always_ff @(posedge clk) begin
    if (rst)       view <= '0;
    else if (!hold) view <= live;
  end
endmodule

// File: rtl/hmbox_sync.sv
module hmbox_sync
  import hmbox_pkg::*;
#(
  parameter  int N_BOX = 3,
  parameter  int DW    = 8,
  localparam int AW    = hmbox_addr_bits(N_BOX),
  localparam int SW    = hmbox_sel_bits(N_BOX)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic [SW-1:0] core_in_sel,
  output logic          core_in_valid,
  output logic [DW-1:0] core_in_data,
  input  logic          core_in_ready,
  input  logic [SW-1:0] core_out_sel,
  input  logic          core_out_valid,
  input  logic [DW-1:0] core_out_data,
  output logic          core_out_ready,
  input  logic          core_stat_rd,
  output logic [DW-1:0] core_h2c_status,
  output logic [DW-1:0] core_c2h_status
);
  localparam logic [AW-1:0] STAT_IN_ADDR  = AW'(2 * N_BOX);
  localparam logic [AW-1:0] STAT_OUT_ADDR = AW'(2 * N_BOX + 1);

  // host strobe synchronization
  logic rd_level, rd_rise, rd_fall;
  logic wr_level, wr_rise, wr_fall;

  hmbox_strobe_sync u_rd_sync (
    .clk(clk), .rst(rst), .strobe_async(host_rd),
    .level(rd_level), .rise(rd_rise), .fall(rd_fall)
  );
  hmbox_strobe_sync u_wr_sync (
    .clk(clk), .rst(rst), .strobe_async(host_wr),
    .level(wr_level), .rise(wr_rise), .fall(wr_fall)
  );

  // capture address and data at start of access, act at end
  logic [AW-1:0] wr_addr_q, rd_addr_q;
  logic [DW-1:0] wr_data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr_q <= '0;
      wr_data_q <= '0;
      rd_addr_q <= '0;
    end else begin
      if (wr_rise) begin
        wr_addr_q <= host_addr;
        wr_data_q <= host_wdata;
      end
      if (rd_rise) rd_addr_q <= host_addr;
    end
  end

  // mailbox storage and flags
  logic [N_BOX-1:0][DW-1:0] in_regs, out_regs;
  logic [N_BOX-1:0]         h2c_flags, c2h_flags;
  logic [N_BOX-1:0]         h2c_set, h2c_clr, c2h_set, c2h_clr;
  logic                     core_take, core_accept;

  assign core_take   = core_in_valid & core_in_ready;
  assign core_accept = core_out_valid & core_out_ready;

  for (genvar i = 0; i < N_BOX; i++) begin : g_box
    assign h2c_set[i] = wr_fall && (wr_addr_q == AW'(i));
    assign h2c_clr[i] = core_take && (core_in_sel == SW'(i));
    assign c2h_set[i] = core_accept && (core_out_sel == SW'(i));
    assign c2h_clr[i] = rd_fall && (rd_addr_q == AW'(N_BOX + i));

    always_ff @(posedge clk) begin
      if (rst) begin
        in_regs[i]  <= '0;
        out_regs[i] <= '0;
      end else begin
        if (h2c_set[i]) in_regs[i]  <= wr_data_q;
        if (c2h_set[i]) out_regs[i] <= core_out_data;
      end
    end
  end

  hmbox_flag_bank #(.N_BOX(N_BOX)) u_h2c_flags (
    .clk(clk), .rst(rst), .set_vec(h2c_set), .clr_vec(h2c_clr), .flags(h2c_flags)
  );
  hmbox_flag_bank #(.N_BOX(N_BOX)) u_c2h_flags (
    .clk(clk), .rst(rst), .set_vec(c2h_set), .clr_vec(c2h_clr), .flags(c2h_flags)
  );

  // status views, one per reader
  logic [2*N_BOX-1:0] live_flags, host_view, core_view;
  logic               host_hold;

  assign live_flags = {c2h_flags, h2c_flags};
  assign host_hold  = rd_level | wr_level;

  hmbox_stat_view #(.W(2 * N_BOX)) u_host_view (
    .clk(clk), .rst(rst), .hold(host_hold), .live(live_flags), .view(host_view)
  );
  hmbox_stat_view #(.W(2 * N_BOX)) u_core_view (
    .clk(clk), .rst(rst), .hold(core_stat_rd), .live(live_flags), .view(core_view)
  );

  assign core_h2c_status = DW'(core_view[N_BOX-1:0]);
  assign core_c2h_status = DW'(core_view[2*N_BOX-1:N_BOX]);

  // core side muxes
  always_comb begin
    core_in_valid = 1'b0;
    core_in_data  = '0;
    for (int i = 0; i < N_BOX; i++) begin
      if (core_in_sel == SW'(i)) begin
        core_in_valid = h2c_flags[i];
        core_in_data  = in_regs[i];
      end
    end
  end

  always_comb begin
    core_out_ready = 1'b0;
    for (int i = 0; i < N_BOX; i++) begin
      if (core_out_sel == SW'(i)) core_out_ready = ~c2h_flags[i];
    end
  end

  // host read mux
  always_comb begin
    host_rdata = '0;
    for (int i = 0; i < N_BOX; i++) begin
      if (host_addr == AW'(i))         host_rdata = in_regs[i];
      if (host_addr == AW'(N_BOX + i)) host_rdata = out_regs[i];
    end
    if (host_addr == STAT_IN_ADDR)  host_rdata = DW'(host_view[N_BOX-1:0]);
    if (host_addr == STAT_OUT_ADDR) host_rdata = DW'(host_view[2*N_BOX-1:N_BOX]);
  end
endmodule

// File: rtl/hmbox_sync_chk.sv
module hmbox_sync_chk #(
  parameter int N_BOX = 3,
  parameter int DW    = 8,
  parameter int AW    = 3,
  parameter int SW    = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic [AW-1:0]            host_addr,
  input logic [DW-1:0]            host_rdata,
  input logic [SW-1:0]            core_in_sel,
  input logic                     core_in_valid,
  input logic                     core_in_ready,
  input logic                     core_out_valid,
  input logic                     core_out_ready,
  input logic                     core_stat_rd,
  input logic [N_BOX-1:0]         h2c_flags,
  input logic [N_BOX-1:0]         c2h_flags,
  input logic [2*N_BOX-1:0]       host_view,
  input logic [2*N_BOX-1:0]       core_view,
  input logic                     host_hold,
  input logic                     wr_fall,
  input logic [N_BOX-1:0][DW-1:0] out_regs
);
  a_r7_host_view_frozen: assert property (@(posedge clk) disable iff (rst)
    $past(host_hold) |-> $stable(host_view));

  a_r8_core_view_frozen: assert property (@(posedge clk) disable iff (rst)
    $past(core_stat_rd) |-> $stable(core_view));

  a_r9_host_view_lag: assert property (@(posedge clk) disable iff (rst)
    !$past(host_hold) |-> host_view == $past({c2h_flags, h2c_flags}));

  a_r9_core_view_lag: assert property (@(posedge clk) disable iff (rst)
    !$past(core_stat_rd) |-> core_view == $past({c2h_flags, h2c_flags}));

  a_r4_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    core_out_valid && !core_out_ready |=> $stable(out_regs));

  a_r3_take_clears: assert property (@(posedge clk) disable iff (rst)
    core_in_valid && core_in_ready && !wr_fall && (core_in_sel < SW'(N_BOX))
      |=> $countones(h2c_flags) + 1 == $countones($past(h2c_flags)));

  a_r6_status_pad: assert property (@(posedge clk) disable iff (rst)
    (host_addr == AW'(2 * N_BOX) || host_addr == AW'(2 * N_BOX + 1))
      |-> (host_rdata >> N_BOX) == '0);
endmodule

bind hmbox_sync hmbox_sync_chk #(.N_BOX(N_BOX), .DW(DW), .AW(AW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_rdata(host_rdata),
  .core_in_sel(core_in_sel), .core_in_valid(core_in_valid), .core_in_ready(core_in_ready),
  .core_out_valid(core_out_valid), .core_out_ready(core_out_ready),
  .core_stat_rd(core_stat_rd), .h2c_flags(h2c_flags), .c2h_flags(c2h_flags),
  .host_view(host_view), .core_view(core_view), .host_hold(host_hold),
  .wr_fall(wr_fall), .out_regs(out_regs)
);

// File: tb/hmbox_sync_bench.sv
`timescale 1ns/1ps
module hmbox_sync_bench;
  localparam int N  = 3;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_rd = 1'b0, host_wr = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic [SW-1:0] core_in_sel = '0;
  logic          core_in_valid;
  logic [DW-1:0] core_in_data;
  logic          core_in_ready = 1'b0;
  logic [SW-1:0] core_out_sel = '0;
  logic          core_out_valid = 1'b0;
  logic [DW-1:0] core_out_data = '0;
  logic          core_out_ready;
  logic          core_stat_rd = 1'b0;
  logic [DW-1:0] core_h2c_status, core_c2h_status;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #4 clk = ~clk;

  hmbox_sync u_hmbox_sync (
    .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .core_in_sel(core_in_sel), .core_in_valid(core_in_valid),
    .core_in_data(core_in_data), .core_in_ready(core_in_ready),
    .core_out_sel(core_out_sel), .core_out_valid(core_out_valid),
    .core_out_data(core_out_data), .core_out_ready(core_out_ready),
    .core_stat_rd(core_stat_rd), .core_h2c_status(core_h2c_status),
    .core_c2h_status(core_c2h_status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      finish_run();
    end
  end

  task automatic host_write(input int a, input logic [DW-1:0] d);
    @(negedge clk); #($urandom_range(0, 3));
    host_addr = AW'(a); host_wdata = d; #1;
    host_wr = 1'b1;
    repeat (5) @(posedge clk); #($urandom_range(1, 6));
    host_wr = 1'b0;
    repeat (6) @(posedge clk); @(negedge clk);
  endtask

  task automatic host_read(input int a, output logic [DW-1:0] d);
    @(negedge clk); #($urandom_range(0, 3));
    host_addr = AW'(a); #1;
    host_rd = 1'b1;
    repeat (5) @(posedge clk); #($urandom_range(1, 6));
    d = host_rdata;
    host_rd = 1'b0;
    repeat (6) @(posedge clk); @(negedge clk);
  endtask

  task automatic core_take(input int i);
    @(negedge clk); core_in_sel = SW'(i); core_in_ready = 1'b1;
    @(negedge clk); core_in_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    host_read(2 * N, d);     check("R1 in-status after reset", d, 0);
    host_read(2 * N + 1, d); check("R1 out-status after reset", d, 0);
    core_in_sel = 0; core_out_sel = 0; #1;
    check("R1 in_valid after reset", core_in_valid, 0);
    check("R1 out_ready after reset", core_out_ready, 1);
    check("R1 core status after reset", {core_h2c_status, core_c2h_status}, 0);
  endtask

  task automatic t_host_to_core();
    logic [DW-1:0] d;
    for (int i = 0; i < N; i++) host_write(i, DW'(8'h31 + 8'h11 * i));
    for (int i = 0; i < N; i++) begin
      core_in_sel = SW'(i); #1;
      check("R2 in_valid after host write", core_in_valid, 1);
      check("R2 in_data after host write", core_in_data, 8'h31 + 8'h11 * i);
    end
    host_read(2 * N, d);
    check("R6 in-status all set, high bits zero", d, 8'h07);
    check("R6 core in-status", core_h2c_status, 8'h07);
    for (int i = 0; i < N; i++) begin
      core_take(i);
      check("R3 in_valid cleared by take", core_in_valid, 0);
    end
    host_read(2 * N, d);
    check("R3 in-status cleared", d, 0);
  endtask

  task automatic t_core_to_host();
    logic [DW-1:0] d;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      core_out_sel = SW'(i); core_out_data = DW'(8'hA0 + i); core_out_valid = 1'b1;
      check("R4 ready before write", core_out_ready, 1);
      @(negedge clk);
      check("R4 ready low after write", core_out_ready, 0);
      core_out_data = 8'h5F;
      @(negedge clk);
      core_out_valid = 1'b0;
      host_read(2 * N + 1, d);
      check("R6 out-status bit", d, 8'h01 << i);
      host_read(N + i, d);
      check("R4 R5 outbound data not overwritten", d, 8'hA0 + i);
      check("R5 ready after host read", core_out_ready, 1);
      host_read(2 * N + 1, d);
      check("R5 out-status cleared", d, 0);
    end
  endtask

  task automatic t_host_freeze();
    logic [DW-1:0] d;
    host_write(0, 8'h77);
    @(negedge clk); #($urandom_range(0, 3));
    host_addr = AW'(2 * N); #1;
    host_rd = 1'b1;
    repeat (5) @(posedge clk);
    core_take(0);
    repeat (3) @(posedge clk); #($urandom_range(1, 6));
    check("R7 host status held during read", host_rdata, 8'h01);
    host_rd = 1'b0;
    repeat (6) @(posedge clk); @(negedge clk);
    host_read(2 * N, d);
    check("R7 change visible after read", d, 0);
  endtask

  task automatic t_core_freeze();
    @(negedge clk); core_stat_rd = 1'b1;
    host_write(2, 8'h4C);
    core_in_sel = 2; #1;
    check("R8 live flag set during hold", core_in_valid, 1);
    check("R8 core status held", core_h2c_status, 0);
    @(negedge clk); core_stat_rd = 1'b0;
    @(negedge clk);
    check("R8 core status after release", core_h2c_status, 8'h04);
    core_take(2);
  endtask

  task automatic t_lag();
    logic [DW-1:0] d;
    @(negedge clk);
    core_out_sel = 1; core_out_data = 8'hE1; core_out_valid = 1'b1;
    @(negedge clk);
    core_out_valid = 1'b0;
    check("R9 flag set at edge", core_out_ready, 0);
    check("R9 status one cycle behind", core_c2h_status, 0);
    @(negedge clk);
    check("R9 status caught up", core_c2h_status, 8'h02);
    host_read(N + 1, d);
  endtask

  task automatic t_sync_latency();
    @(negedge clk); #($urandom_range(0, 3));
    host_addr = 1; host_wdata = 8'h9D; #1;
    host_wr = 1'b1;
    repeat (5) @(posedge clk); #($urandom_range(1, 6));
    host_wr = 1'b0;
    core_in_sel = 1;
    repeat (2) @(posedge clk); #1;
    check("R10 flag not yet set after two edges", core_in_valid, 0);
    @(posedge clk); #1;
    check("R10 flag set on third edge", core_in_valid, 1);
    check("R10 data", core_in_data, 8'h9D);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    core_out_sel = 0; core_out_data = 8'h12; core_out_valid = 1'b1;
    @(negedge clk); core_out_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    core_in_sel = 1; #1;
    check("R1 inbound flag cleared by reset", core_in_valid, 0);
    check("R1 inbound data cleared by reset", core_in_data, 0);
    check("R1 outbound ready after reset", core_out_ready, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_host_to_core();
    t_core_to_host();
    t_host_freeze();
    t_core_freeze();
    t_lag();
    t_sync_latency();
    t_reset_mid();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule